// File: doc/BRIEF.md
# Handshaked SPI Slave Packet Endpoint

This block is the device end of an extended SPI link that adds a handshake line. The host drives the serial clock, an active-low select and the host-to-device data. The block returns device-to-host data and drives one active-low request line. That line has two meanings. While the bus is idle, a low level means the device has a packet waiting for the host. Once the host has pulled select low, a low level means the device is ready for the transfer. Bits travel most-significant first. Both sides sample on the falling clock edge and change data on the rising edge.

Host writes start with opcode 0x01. A two-byte big-endian length follows, then two filler bytes, then the payload. The endpoint passes payload bytes to a local sink, one byte per pulse, and marks the first and last byte. When select rises it reports the end of the packet and flags it if fewer bytes arrived than the length promised. For host reads, local logic raises a request and supplies a length and a random-access byte buffer. The endpoint answers a read opcode (0x03) with a fixed lead byte, two zero bytes, the length and the payload. Local logic learns through a done pulse that the whole reply was clocked out. All three host inputs pass through two-flop synchronizers into the system clock domain, so the serial clock must run at no more than a quarter of the system clock.

Top module: `hspi_endpoint`

## Requirements
- R1: After reset the request line `irq_n` is high, `spi_miso` is 0, and `rx_valid`, `rx_end` and `tx_done` are 0.
- R2: While select is high, `tx_req` is 1 and no release hold-off is running, `irq_n` is driven low.
- R3: While select is low, `irq_n` is low. After select rises with `tx_req` at 0, `irq_n` returns high.
- R4: In a write (first byte 0x01, byte positions 1 and 2 holding the length MSB then LSB, positions 3 and 4 ignored), each payload byte from position 5 on is delivered once on `rx_data` with a one-cycle `rx_valid`. `rx_first` is set on the first payload byte and `rx_last` on the byte whose count equals the length. Bytes beyond the length are dropped. Every byte is assembled MSB first from bits sampled on falling SCLK edges.
- R5: When select rises after a write, `rx_end` pulses for one cycle. `rx_bad` is 1 if the length field was incomplete or fewer payload bytes arrived than it gave, and 0 otherwise.
- R6: During a transfer that began with `tx_req` high, MISO carries 0x02 in byte 0. If byte 0 received is 0x03, bytes 1 and 2 are 0x00, bytes 3 and 4 are `tx_len` MSB then LSB, bytes 5 on are `tx_data` at `tx_addr` = position - 5, and bytes past the length are 0x00. Bits change on rising SCLK edges, MSB first.
- R7: If byte 0 of a transfer is neither a read with a pending request nor 0x01, every later MISO byte is 0x00 and neither `rx_end` nor `tx_done` pulses. If no request was pending at select fall, byte 0 on MISO is also 0x00.
- R8: `tx_done` pulses once when select rises after a read in which all 5 + `tx_len` bytes were clocked. It does not pulse after a shorter read, and it never coincides with `rx_end`.
- R9: While select is high, MISO holds its last value even when SCLK toggles, and no receive event occurs.
- R10: After select rises, `irq_n` stays high for at least GAP_CYC cycles even if `tx_req` is 1, then falls again if the request remains.
- R11: A write with length 0 delivers no byte and ends with `rx_bad` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sclk | input | 1 | Serial clock from host, idle low |
| spi_cs_n | input | 1 | Active-low select from host |
| spi_mosi | input | 1 | Host-to-device data |
| spi_miso | output | 1 | Device-to-host data, always driven |
| irq_n | output | 1 | Active-low pending/ready handshake |
| tx_req | input | 1 | Local packet waiting for the host |
| tx_len | input | LEN_W | Payload length of the waiting packet |
| tx_addr | output | LEN_W | Payload byte index being fetched |
| tx_data | input | 8 | Payload byte at `tx_addr` |
| tx_done | output | 1 | Pulse: whole reply clocked out |
| rx_valid | output | 1 | Pulse: payload byte on `rx_data` |
| rx_data | output | 8 | Received payload byte |
| rx_first | output | 1 | With `rx_valid`: first payload byte |
| rx_last | output | 1 | With `rx_valid`: final byte per length |
| rx_end | output | 1 | Pulse: write packet closed |
| rx_bad | output | 1 | With `rx_end`: packet short or header cut |

## Verification
Two cases meet in the same cycle. In the first, the select rising edge that closes a transaction coincides with a request still pending, so the release of the handshake line and the renewed "data waiting" announcement compete. The bench keeps `tx_req` high through a read and watches `irq_n` in the cycles after select rises: it must stay high for the hold-off and only then drop. In the second, the byte-count pulse and the end-of-transfer pulse both touch the packet accounting. Truncated, exact and over-long writes, and full and partial reads, are each judged from the `rx_end`/`rx_bad` and `tx_done` pulses. A reference model of the handshake level is compared on every settled clock.

// File: rtl/spi_ep_pkg.sv
`timescale 1ns/1ps
package spi_ep_pkg;
  localparam logic [7:0] OP_WRITE  = 8'h01;
  localparam logic [7:0] OP_READ   = 8'h03;
  localparam logic [7:0] REPLY_TAG = 8'h02;
  localparam logic [7:0] FILL_BYTE = 8'h00;
  localparam int         HDR_BYTES = 5;

  typedef enum logic [1:0] {
    XF_IDLE  = 2'd0,
    XF_WRITE = 2'd1,
    XF_READ  = 2'd2,
    XF_SKIP  = 2'd3
  } xfer_mode_t;
endpackage

// File: rtl/spi_ep_sync.sv
`timescale 1ns/1ps
// Multi-stage level synchronizer, one flop chain per bit.
module spi_ep_sync #(
  parameter int         W       = 3,
  parameter int         STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_in,
  output logic [W-1:0] d_sync
);
  for (genvar g = 0; g < STAGES; g++) begin : g_stg
    logic [W-1:0] r;
    if (g == 0) begin : g_head
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r <= RST_VAL;
        else        r <= d_in;
      end
    end else begin : g_tail
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r <= RST_VAL;
        else        r <= g_stg[g-1].r;
      end
    end
  end

  assign d_sync = g_stg[STAGES-1].r;
endmodule

// File: rtl/spi_ep_shift.sv
`timescale 1ns/1ps
// Bit engine: samples host data on SCLK fall, launches reply bits on SCLK rise.
module spi_ep_shift #(
  parameter int BITS = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cs_act,
  input  logic            sclk_s,
  input  logic            mosi_s,
  input  logic [BITS-1:0] tx_byte,
  output logic            byte_done,
  output logic [BITS-1:0] rx_byte,
  output logic            miso
);
  localparam int CW = $clog2(BITS);
  localparam logic [CW-1:0] LAST_BIT = CW'(BITS - 1);

  logic            sclk_q;
  logic [CW-1:0]   bit_cnt, bit_cnt_d;
  logic [BITS-2:0] in_sr,   in_sr_d;
  logic [BITS-1:0] out_sr,  out_sr_d;
  logic [BITS-1:0] rx_q,    rx_d;
  logic            miso_q,  miso_d;
  logic            done_q,  done_d;
  logic            s_rise,  s_fall;

  assign s_rise = sclk_s & ~sclk_q;
  assign s_fall = ~sclk_s & sclk_q;

  always_comb begin
    bit_cnt_d = bit_cnt;
    in_sr_d   = in_sr;
    out_sr_d  = out_sr;
    rx_d      = rx_q;
    miso_d    = miso_q;
    done_d    = 1'b0;
    if (!cs_act) begin
      bit_cnt_d = '0;
    end else begin
      if (s_fall) begin
        in_sr_d = {in_sr[BITS-3:0], mosi_s};
        if (bit_cnt == LAST_BIT) begin
          bit_cnt_d = '0;
          done_d    = 1'b1;
          rx_d      = {in_sr, mosi_s};
        end else begin
          bit_cnt_d = bit_cnt + 1'b1;
        end
      end
      if (s_rise) begin
        if (bit_cnt == '0) begin
          miso_d   = tx_byte[BITS-1];
          out_sr_d = {tx_byte[BITS-2:0], 1'b0};
        end else begin
          miso_d   = out_sr[BITS-1];
          out_sr_d = {out_sr[BITS-2:0], 1'b0};
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q  <= 1'b0;
      bit_cnt <= '0;
      in_sr   <= '0;
      out_sr  <= '0;
      rx_q    <= '0;
      miso_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      sclk_q  <= sclk_s;
      bit_cnt <= bit_cnt_d;
      in_sr   <= in_sr_d;
      out_sr  <= out_sr_d;
      rx_q    <= rx_d;
      miso_q  <= miso_d;
      done_q  <= done_d;
    end
  end

  assign byte_done = done_q;
  assign rx_byte   = rx_q;
  assign miso      = miso_q;
endmodule

// File: rtl/spi_ep_ctrl.sv
`timescale 1ns/1ps
// Packet layer: opcode decode, length parsing, reply byte selection, handshake.
module spi_ep_ctrl
  import spi_ep_pkg::*;
#(
  parameter int LEN_W   = 16,
  parameter int GAP_CYC = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_s,
  input  logic             byte_done,
  input  logic [7:0]       rx_byte,
  input  logic             tx_req,
  input  logic [LEN_W-1:0] tx_len,
  input  logic [7:0]       tx_data,
  output logic [7:0]       tx_byte,
  output logic [LEN_W-1:0] tx_addr,
  output logic             tx_done,
  output logic             rx_valid,
  output logic [7:0]       rx_data,
  output logic             rx_first,
  output logic             rx_last,
  output logic             rx_end,
  output logic             rx_bad,
  output logic             irq_n
);
  localparam int IDX_W = LEN_W + 1;
  localparam int GAP_W = $clog2(GAP_CYC + 1);
  localparam logic [IDX_W-1:0] HDR    = IDX_W'(HDR_BYTES);
  localparam logic [IDX_W-1:0] POS_L1 = IDX_W'(1);
  localparam logic [IDX_W-1:0] POS_L2 = IDX_W'(2);
  localparam logic [IDX_W-1:0] POS_N1 = IDX_W'(3);
  localparam logic [IDX_W-1:0] POS_N2 = IDX_W'(4);

  logic             cs_q;
  logic             cs_act, cs_fall, cs_rise;
  logic [IDX_W-1:0] idx_q,   idx_d;
  xfer_mode_t       mode_q,  mode_d;
  logic [LEN_W-1:0] len_q,   len_d;
  logic             lok_q,   lok_d;
  logic [IDX_W-1:0] rcv_q,   rcv_d;
  logic             pend_q,  pend_d;
  logic [LEN_W-1:0] tlen_q,  tlen_d;
  logic [GAP_W-1:0] gap_q,   gap_d;
  logic             irq_q,   irq_d;
  logic             vld_q,   vld_d;
  logic [7:0]       dat_q,   dat_d;
  logic             fst_q,   fst_d;
  logic             lst_q,   lst_d;
  logic             end_q,   end_d;
  logic             bad_q,   bad_d;
  logic             done_q,  done_d;
  logic [IDX_W-1:0] pay_idx;
  logic [IDX_W-1:0] wlen_x, tlen_x;

  assign cs_act  = ~cs_s;
  assign cs_fall = ~cs_s & cs_q;
  assign cs_rise = cs_s & ~cs_q;
  assign pay_idx = idx_q - HDR;
  assign wlen_x  = {1'b0, len_q};
  assign tlen_x  = {1'b0, tlen_q};

  // Reply byte for the position about to be shifted out.
  always_comb begin
    tx_byte = FILL_BYTE;
    if (idx_q == '0) begin
      tx_byte = pend_q ? REPLY_TAG : FILL_BYTE;
    end else if (mode_q == XF_READ) begin
      if (idx_q == POS_N1)      tx_byte = tlen_q[LEN_W-1 -: 8];
      else if (idx_q == POS_N2) tx_byte = tlen_q[7:0];
      else if (idx_q >= HDR && pay_idx < tlen_x) tx_byte = tx_data;
    end
  end

  assign tx_addr = pay_idx[LEN_W-1:0];

  always_comb begin
    idx_d  = idx_q;
    mode_d = mode_q;
    len_d  = len_q;
    lok_d  = lok_q;
    rcv_d  = rcv_q;
    pend_d = pend_q;
    tlen_d = tlen_q;
    gap_d  = gap_q;
    dat_d  = dat_q;
    bad_d  = bad_q;
    vld_d  = 1'b0;
    fst_d  = 1'b0;
    lst_d  = 1'b0;
    end_d  = 1'b0;
    done_d = 1'b0;

    if (cs_fall) begin
      idx_d  = '0;
      mode_d = XF_IDLE;
      lok_d  = 1'b0;
      rcv_d  = '0;
      pend_d = tx_req;
      tlen_d = tx_len;
    end else if (byte_done) begin
      if (idx_q != '1) idx_d = idx_q + 1'b1;
      if (idx_q == '0) begin
        if (rx_byte == OP_READ && pend_q) mode_d = XF_READ;
        else if (rx_byte == OP_WRITE)     mode_d = XF_WRITE;
        else                              mode_d = XF_SKIP;
      end else if (mode_q == XF_WRITE) begin
        if (idx_q == POS_L1 || idx_q == POS_L2) begin
          len_d = {len_q[LEN_W-9:0], rx_byte};
          if (idx_q == POS_L2) lok_d = 1'b1;
        end else if (idx_q >= HDR && rcv_q < wlen_x) begin
          vld_d = 1'b1;
          dat_d = rx_byte;
          fst_d = (rcv_q == '0);
          lst_d = (rcv_q == wlen_x - 1'b1);
          rcv_d = rcv_q + 1'b1;
        end
      end
    end

    if (cs_rise) begin
      if (mode_q == XF_WRITE) begin
        end_d = 1'b1;
        bad_d = !lok_q || (rcv_q != wlen_x);
      end
      if (mode_q == XF_READ && idx_q >= HDR + tlen_x) done_d = 1'b1;
      mode_d = XF_IDLE;
      gap_d  = GAP_W'(GAP_CYC);
    end else if (gap_q != '0) begin
      gap_d = gap_q - 1'b1;
    end

    irq_d = ~(cs_act | (tx_req & (gap_q == '0) & ~cs_rise));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q   <= 1'b1;
      idx_q  <= '0;
      mode_q <= XF_IDLE;
      len_q  <= '0;
      lok_q  <= 1'b0;
      rcv_q  <= '0;
      pend_q <= 1'b0;
      tlen_q <= '0;
      gap_q  <= '0;
      irq_q  <= 1'b1;
      vld_q  <= 1'b0;
      dat_q  <= '0;
      fst_q  <= 1'b0;
      lst_q  <= 1'b0;
      end_q  <= 1'b0;
      bad_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      cs_q   <= cs_s;
      idx_q  <= idx_d;
      mode_q <= mode_d;
      len_q  <= len_d;
      lok_q  <= lok_d;
      rcv_q  <= rcv_d;
      pend_q <= pend_d;
      tlen_q <= tlen_d;
      gap_q  <= gap_d;
      irq_q  <= irq_d;
      vld_q  <= vld_d;
      dat_q  <= dat_d;
      fst_q  <= fst_d;
      lst_q  <= lst_d;
      end_q  <= end_d;
      bad_q  <= bad_d;
      done_q <= done_d;
    end
  end

  assign irq_n    = irq_q;
  assign rx_valid = vld_q;
  assign rx_data  = dat_q;
  assign rx_first = fst_q;
  assign rx_last  = lst_q;
  assign rx_end   = end_q;
  assign rx_bad   = bad_q;
  assign tx_done  = done_q;
endmodule

// File: rtl/hspi_endpoint.sv
`timescale 1ns/1ps
module hspi_endpoint #(
  parameter int LEN_W       = 16,
  parameter int GAP_CYC     = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             spi_sclk,
  input  logic             spi_cs_n,
  input  logic             spi_mosi,
  output logic             spi_miso,
  output logic             irq_n,
  input  logic             tx_req,
  input  logic [LEN_W-1:0] tx_len,
  output logic [LEN_W-1:0] tx_addr,
  input  logic [7:0]       tx_data,
  output logic             tx_done,
  output logic             rx_valid,
  output logic [7:0]       rx_data,
  output logic             rx_first,
  output logic             rx_last,
  output logic             rx_end,
  output logic             rx_bad
);
  // Reset: asserted asynchronously, released on a clock edge.
  logic [1:0] rst_pipe;
  logic       rst_ni;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_ni = rst_pipe[1];

  logic [2:0] pins_s;
  logic       sclk_s, cs_s, mosi_s, cs_act;
  logic       byte_done;
  logic [7:0] rx_byte, tx_byte;

  spi_ep_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
    .clk    (clk),
    .rst_n  (rst_ni),
    .d_in   ({spi_sclk, spi_cs_n, spi_mosi}),
    .d_sync (pins_s)
  );
  assign sclk_s = pins_s[2];
  assign cs_s   = pins_s[1];
  assign mosi_s = pins_s[0];
  assign cs_act = ~cs_s;

  spi_ep_shift #(.BITS(8)) u_shift (
    .clk       (clk),
    .rst_n     (rst_ni),
    .cs_act    (cs_act),
    .sclk_s    (sclk_s),
    .mosi_s    (mosi_s),
    .tx_byte   (tx_byte),
    .byte_done (byte_done),
    .rx_byte   (rx_byte),
    .miso      (spi_miso)
  );

  spi_ep_ctrl #(.LEN_W(LEN_W), .GAP_CYC(GAP_CYC)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_ni),
    .cs_s      (cs_s),
    .byte_done (byte_done),
    .rx_byte   (rx_byte),
    .tx_req    (tx_req),
    .tx_len    (tx_len),
    .tx_data   (tx_data),
    .tx_byte   (tx_byte),
    .tx_addr   (tx_addr),
    .tx_done   (tx_done),
    .rx_valid  (rx_valid),
    .rx_data   (rx_data),
    .rx_first  (rx_first),
    .rx_last   (rx_last),
    .rx_end    (rx_end),
    .rx_bad    (rx_bad),
    .irq_n     (irq_n)
  );
endmodule

// File: rtl/hspi_endpoint_chk.sv
`timescale 1ns/1ps
module hspi_endpoint_chk (
  input logic clk,
  input logic rst_n,
  input logic cs_act,
  input logic miso,
  input logic irq_n,
  input logic rx_valid,
  input logic rx_first,
  input logic rx_last,
  input logic rx_end,
  input logic tx_done
);
  AST_FIRST_WITH_BEAT: assert property (@(posedge clk) disable iff (!rst_n) rx_first |-> rx_valid); // R4
  AST_LAST_WITH_BEAT: assert property (@(posedge clk) disable iff (!rst_n) rx_last |-> rx_valid); // R4
  AST_END_DONE_APART: assert property (@(posedge clk) disable iff (!rst_n) !(rx_end && tx_done)); // R8
  AST_MISO_HELD_IDLE: assert property (@(posedge clk) disable iff (!rst_n) (!cs_act && $past(!cs_act)) |-> $stable(miso)); // R9
  AST_IRQ_LOW_SELECTED: assert property (@(posedge clk) disable iff (!rst_n) cs_act |=> !irq_n); // R3
  AST_IRQ_RELEASE_HOLD: assert property (@(posedge clk) disable iff (!rst_n) $fell(cs_act) |=> irq_n); // R10
endmodule

bind hspi_endpoint hspi_endpoint_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_ni),
  .cs_act   (cs_act),
  .miso     (spi_miso),
  .irq_n    (irq_n),
  .rx_valid (rx_valid),
  .rx_first (rx_first),
  .rx_last  (rx_last),
  .rx_end   (rx_end),
  .tx_done  (tx_done)
);

// File: tb/hspi_endpoint_tb_top.sv
`timescale 1ns/1ps
module hspi_endpoint_tb_top;
  localparam int HALF = 4;

  logic        clk, rst_n, sclk, cs_n, mosi, tx_req;
  logic [15:0] tx_len;
  logic [15:0] tx_addr;
  logic [7:0]  tx_data;
  logic        miso, irq_n, tx_done, rx_valid, rx_first, rx_last, rx_end, rx_bad;
  logic [7:0]  rx_data;
  logic [7:0]  tx_mem [8];

  int n_cmp = 0, n_bad = 0;
  bit finished = 0;

  hspi_endpoint dut_i (
    .clk(clk), .rst_n(rst_n), .spi_sclk(sclk), .spi_cs_n(cs_n), .spi_mosi(mosi),
    .spi_miso(miso), .irq_n(irq_n), .tx_req(tx_req), .tx_len(tx_len),
    .tx_addr(tx_addr), .tx_data(tx_data), .tx_done(tx_done), .rx_valid(rx_valid),
    .rx_data(rx_data), .rx_first(rx_first), .rx_last(rx_last), .rx_end(rx_end),
    .rx_bad(rx_bad)
  );

  assign tx_data = tx_mem[tx_addr[2:0]];

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  // Event monitor, sampled away from the active edge.
  logic [7:0] got_q [$];
  logic [1:0] flg_q [$];
  int n_end = 0, n_done = 0;
  logic last_bad = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (rx_valid) begin got_q.push_back(rx_data); flg_q.push_back({rx_first, rx_last}); end
      if (rx_end) begin n_end++; last_bad = rx_bad; end
      if (tx_done) n_done++;
    end
  end

  // Per-cycle reference of the handshake level once inputs have settled.
  bit   model_on = 0;
  logic m_cs = 1'b1, m_req = 1'b0;
  int   quiet = 0;
  always @(negedge clk) begin
    if (model_on) begin
      if (cs_n !== m_cs || tx_req !== m_req) begin
        m_cs = cs_n; m_req = tx_req; quiet = 0;
      end else if (quiet < 1000) quiet++;
      if (quiet >= 12)
        chk(irq_n === ((!m_cs || m_req) ? 1'b0 : 1'b1), "R2 R3 irq level", irq_n, (!m_cs || m_req) ? 0 : 1);
    end
  end

  // Host side of one byte: launch on rise, sample on fall, MSB first.
  task automatic xbyte(input logic [7:0] o, output logic [7:0] r);
    for (int b = 7; b >= 0; b--) begin
      @(negedge clk); sclk = 1'b1; mosi = o[b];
      repeat (HALF) @(negedge clk);
      r[b] = miso; sclk = 1'b0;
      repeat (HALF - 1) @(negedge clk);
    end
  endtask

  logic [7:0] hout [$];
  logic [7:0] hin  [$];

  task automatic xfer();
    logic [7:0] r;
    int wait_n;
    hin.delete();
    @(negedge clk); cs_n = 1'b0;
    wait_n = 0;
    while (irq_n !== 1'b0 && wait_n < 50) begin @(negedge clk); wait_n++; end
    chk(irq_n === 1'b0, "R3 ready after select", irq_n, 0);
    repeat (4) @(negedge clk);
    foreach (hout[i]) begin xbyte(hout[i], r); hin.push_back(r); end
    repeat (HALF) @(negedge clk);
    cs_n = 1'b1;
  endtask

  task automatic settle();
    repeat (16) @(negedge clk);
  endtask

  task automatic write_pkt(input int len, input int npay, input logic [7:0] base);
    hout = {8'h01, 8'(len >> 8), 8'(len), 8'h00, 8'h00};
    for (int i = 0; i < npay; i++) hout.push_back(base ^ 8'(i * 37));
    xfer();
    settle();
  endtask

  initial begin
    logic [7:0] exp_b;
    int e0, d0;
    rst_n = 1'b0; sclk = 1'b0; cs_n = 1'b1; mosi = 1'b0; tx_req = 1'b0; tx_len = 16'd0;
    for (int i = 0; i < 8; i++) tx_mem[i] = 8'h10 + 8'(i);
    tx_mem[1] = 8'h81;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(irq_n === 1'b1, "R1 irq_n after reset", irq_n, 1);
    chk(miso === 1'b0, "R1 miso after reset", miso, 0);
    chk({rx_valid, rx_end, tx_done} === 3'b000, "R1 pulses after reset", {rx_valid, rx_end, tx_done}, 0);
    model_on = 1;
    settle();

    // Exact-length write plus one extra byte past the length.
    got_q.delete(); flg_q.delete(); e0 = n_end;
    write_pkt(6, 7, 8'hA5);
    chk(got_q.size() == 6, "R4 payload count", got_q.size(), 6);
    for (int i = 0; i < 6 && i < got_q.size(); i++) begin
      exp_b = 8'hA5 ^ 8'(i * 37);
      chk(got_q[i] === exp_b, "R4 payload byte", got_q[i], exp_b);
      chk(flg_q[i] === {i == 0, i == 5}, "R4 first/last marks", flg_q[i], {i == 0, i == 5});
    end
    chk(n_end == e0 + 1 && last_bad === 1'b0, "R5 complete write flagged good", {n_end - e0, last_bad}, 2);
    foreach (hin[i]) chk(hin[i] === 8'h00, "R7 no pending reply is zero", hin[i], 0);

    // Short payload: malformed.
    got_q.delete(); e0 = n_end;
    write_pkt(4, 2, 8'h3C);
    chk(got_q.size() == 2, "R5 short write bytes", got_q.size(), 2);
    chk(n_end == e0 + 1 && last_bad === 1'b1, "R5 short write flagged bad", {n_end - e0, last_bad}, 3);

    // Header cut inside the length field: malformed.
    e0 = n_end;
    hout = {8'h01, 8'h00};
    xfer(); settle();
    chk(n_end == e0 + 1 && last_bad === 1'b1, "R5 cut header flagged bad", {n_end - e0, last_bad}, 3);

    // Zero-length write.
    got_q.delete(); e0 = n_end;
    write_pkt(0, 0, 8'h00);
    chk(got_q.size() == 0, "R11 zero length no bytes", got_q.size(), 0);
    chk(n_end == e0 + 1 && last_bad === 1'b0, "R11 zero length good", {n_end - e0, last_bad}, 2);

    // Pending packet: announcement while idle.
    tx_len = 16'd5; tx_req = 1'b1;
    settle();
    chk(irq_n === 1'b0, "R2 pending announced", irq_n, 0);

    // Full read, then watch release hold-off with request still set.
    d0 = n_done; e0 = n_end;
    hout = {8'h03};
    for (int i = 0; i < 11; i++) hout.push_back(8'h00);
    xfer();
    for (int k = 1; k <= 7; k++) begin
      @(negedge clk);
      if (k >= 4) chk(irq_n === 1'b1, "R10 hold-off after deselect", irq_n, 1);
    end
    repeat (3) @(negedge clk);
    chk(irq_n === 1'b0, "R10 re-announce after hold-off", irq_n, 0);
    for (int i = 0; i < 12; i++) begin
      if (i == 0) exp_b = 8'h02;
      else if (i == 4) exp_b = 8'h05;
      else if (i >= 5 && i < 10) exp_b = tx_mem[i - 5];
      else exp_b = 8'h00;
      chk(hin[i] === exp_b, "R6 reply byte", hin[i], exp_b);
    end
    chk(n_done == d0 + 1, "R8 done after full read", n_done - d0, 1);
    chk(n_end == e0, "R8 no write end on read", n_end - e0, 0);

    // Wrong opcode with request pending.
    d0 = n_done; e0 = n_end;
    hout = {8'h05};
    for (int i = 0; i < 9; i++) hout.push_back(8'hFF);
    xfer(); settle();
    chk(hin[0] === 8'h02, "R7 lead byte before decode", hin[0], 8'h02);
    for (int i = 1; i < 10; i++) chk(hin[i] === 8'h00, "R7 silent after bad opcode", hin[i], 0);
    chk(n_done == d0 && n_end == e0, "R7 no completion events", {n_done - d0, n_end - e0}, 0);

    // Partial read: no completion.
    d0 = n_done;
    hout = {8'h03, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00};
    xfer(); settle();
    chk(hin[5] === tx_mem[0] && hin[6] === tx_mem[1], "R6 partial reply data", {hin[5], hin[6]}, {tx_mem[0], tx_mem[1]});
    chk(n_done == d0, "R8 no done on partial read", n_done - d0, 0);
    tx_req = 1'b0;
    settle();

    // SCLK activity while deselected.
    begin
      logic m0;
      int g0;
      m0 = miso; g0 = got_q.size(); e0 = n_end;
      for (int i = 0; i < 16; i++) begin
        @(negedge clk); sclk = 1'b1; mosi = i[0];
        repeat (HALF) @(negedge clk);
        chk(miso === m0, "R9 miso held while deselected", miso, m0);
        sclk = 1'b0;
        repeat (HALF) @(negedge clk);
      end
      settle();
      chk(got_q.size() == g0 && n_end == e0, "R9 no receive while deselected", got_q.size() - g0, 0);
    end

    summary();
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    summary();
  end
endmodule